// File: doc/BRIEF.md
# Embedded Operation Toggle Status Logic

This block generates the two toggle status bits that a flash-style memory returns when it is read while an internal program or erase runs. One bit, the mode toggle (status bit 6), shows whether an embedded algorithm is still working on the bank. The other, the sector toggle (status bit 2), shows whether the sector being read has been picked for erase, whether that erase is running or suspended. A third output tells the read path to return this status word instead of array data.

The surrounding controller supplies the current operation state, the erase-selection and protection masks, the sector a program targets and a one-cycle start pulse issued on the final write of a command sequence. The read path supplies a read strobe, the active-low output enable and the sector of the read address. When a started erase finds every selected sector protected, or a program targets a protected sector, no algorithm runs. The block then times a fixed toggle window itself and drops back to array mode when the window ends. All inputs are plain control levels; the block has no data stream and no back-pressure.

Top module: `tgl_status_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, both toggle bits and the status-select flag are 0.
- R2: A counted read is a clock edge with `rd_strobe`=1 and `oe_n`=0. Each counted read inverts the mode toggle while `op_state` is program (1), erase (2) or erase-suspend-program (4), or while a protection window runs; the new value shows after that edge.
- R3: A read with `oe_n`=1 changes neither toggle bit.
- R4: In erase-suspend (3) and idle (0) the mode toggle holds its value across reads when no protection window runs.
- R5: Each counted read to a sector whose `erase_sel` bit is 1 inverts the sector toggle while `op_state` is 2, 3 or 4. Reads to unselected sectors, and all reads in states 0 and 1, leave it unchanged.
- R6: An edge with `op_start`=1 clears both toggle bits to 0, and this overrides a counted read on the same edge.
- R7: A start with `op_state`=2, a non-zero `erase_sel` and every selected sector protected opens a protection window of `ALLPROT_CYC` cycles after that edge.
- R8: A start with `op_state` 1 or 4 whose `prog_sector` is protected opens a protection window of `PROGPROT_CYC` cycles after that edge.
- R9: `status_sel_o` is 1 while `op_state` is 1 to 4 or a protection window runs, and 0 otherwise, which returns reads to array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse on the final command write |
| op_state | input | 3 | 0 idle, 1 program, 2 erase, 3 erase-suspend, 4 erase-suspend-program |
| erase_sel | input | NSEC | Sectors selected for erase |
| prot_mask | input | NSEC | Protected sectors |
| prog_sector | input | log2(NSEC) | Sector targeted by a program |
| rd_sector | input | log2(NSEC) | Sector of the current read address |
| rd_strobe | input | 1 | Read cycle marker |
| oe_n | input | 1 | Output enable, active low |
| tgl_mode_o | output | 1 | Mode toggle (status bit 6) |
| tgl_sect_o | output | 1 | Sector toggle (status bit 2) |
| status_sel_o | output | 1 | 1 selects status word instead of array data |

## Verification
The hardest case to reach from the ports is the end of a protection window while reads continue and the controller has already gone idle. Only the window timer keeps the mode toggle running there, and `status_sel_o` must fall on an exact cycle. Directed sequences start an all-protected erase and a protected program, keep reading through the window and check its last and first-outside cycles. Random stimulus biases the protection mask to cover the erase selection on many starts, so windows also open, restart and overlap with state changes.

// File: rtl/tgl_pkg.sv
package tgl_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_ESUSP  = 3'd3,
    OP_ESPROG = 3'd4
  } op_state_e;

  // Mode toggle runs while an algorithm actively executes.
  function automatic logic mode_runs(input logic [2:0] st);
    return (st == OP_PROG) || (st == OP_ERASE) || (st == OP_ESPROG);
  endfunction

  // Sector toggle runs while an erase exists, active or suspended.
  function automatic logic erase_exists(input logic [2:0] st);
    return (st == OP_ERASE) || (st == OP_ESUSP) || (st == OP_ESPROG);
  endfunction

  // Any legal non-idle state keeps the read path on status.
  function automatic logic is_busy(input logic [2:0] st);
    return mode_runs(st) || (st == OP_ESUSP);
  endfunction

  function automatic logic is_prog_kind(input logic [2:0] st);
    return (st == OP_PROG) || (st == OP_ESPROG);
  endfunction

endpackage

// File: rtl/tgl_prot_check.sv
module tgl_prot_check
  import tgl_pkg::*;
#(
  parameter int NSEC = 16,
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic [2:0]      op_state,
  input  logic [NSEC-1:0] erase_sel,
  input  logic [NSEC-1:0] prot_mask,
  input  logic [SW-1:0]   prog_sector,
  output logic            hit_all_prot,
  output logic            hit_prog_prot
);

  logic [NSEC-1:0] open_sel;
  logic            any_sel;
  logic            any_open;

  always_comb begin
    open_sel = erase_sel & ~prot_mask;
    any_sel  = |erase_sel;
    any_open = |open_sel;
  end

  // Erase where each picked sector is locked: nothing left to erase.
  assign hit_all_prot  = (op_state == OP_ERASE) && any_sel && !any_open;
  // Program aimed at a locked sector.
  assign hit_prog_prot = is_prog_kind(op_state) && prot_mask[prog_sector];

endmodule

// File: rtl/tgl_guard_timer.sv
module tgl_guard_timer #(
  parameter int ALLPROT_CYC  = 40,
  parameter int PROGPROT_CYC = 24,
  localparam int MAXC = (ALLPROT_CYC > PROGPROT_CYC) ? ALLPROT_CYC : PROGPROT_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hit_all_prot,
  input  logic hit_prog_prot,
  output logic guard_on
);

  localparam logic [CW-1:0] LOAD_ALL  = CW'(ALLPROT_CYC);
  localparam logic [CW-1:0] LOAD_PROG = CW'(PROGPROT_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      if (hit_all_prot)       cnt_d = LOAD_ALL;
      else if (hit_prog_prot) cnt_d = LOAD_PROG;
      else                    cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign guard_on = (cnt_q != '0);

endmodule

// File: rtl/tgl_read_qual.sv
module tgl_read_qual
  import tgl_pkg::*;
#(
  parameter int NSEC = 16,
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic [2:0]      op_state,
  input  logic [NSEC-1:0] erase_sel,
  input  logic [SW-1:0]   rd_sector,
  input  logic            rd_strobe,
  input  logic            oe_n,
  input  logic            guard_on,
  output logic            flip_mode,
  output logic            flip_sect
);

  logic counted;
  logic mode_live;
  logic sect_live;

  always_comb begin
    counted   = rd_strobe && !oe_n;
    mode_live = mode_runs(op_state) || guard_on;
    sect_live = erase_exists(op_state) && erase_sel[rd_sector];
    flip_mode = counted && mode_live;
    flip_sect = counted && sect_live;
  end

endmodule

// File: rtl/tgl_flip.sv
module tgl_flip (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic flip,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (clear) q <= 1'b0;
    else if (flip)  q <= ~q;
  end

endmodule

// File: rtl/tgl_status_unit.sv
module tgl_status_unit
  import tgl_pkg::*;
#(
  parameter int NSEC         = 16,
  parameter int ALLPROT_CYC  = 40,
  parameter int PROGPROT_CYC = 24,
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic [2:0]      op_state,
  input  logic [NSEC-1:0] erase_sel,
  input  logic [NSEC-1:0] prot_mask,
  input  logic [SW-1:0]   prog_sector,
  input  logic [SW-1:0]   rd_sector,
  input  logic            rd_strobe,
  input  logic            oe_n,
  output logic            tgl_mode_o,
  output logic            tgl_sect_o,
  output logic            status_sel_o
);

  localparam int NBITS = 2;

  logic hit_all_prot;
  logic hit_prog_prot;
  logic guard_on;
  logic flip_mode;
  logic flip_sect;
  logic [NBITS-1:0] flip_vec;
  logic [NBITS-1:0] q_vec;

  tgl_prot_check #(.NSEC(NSEC)) u_prot (
    .op_state     (op_state),
    .erase_sel    (erase_sel),
    .prot_mask    (prot_mask),
    .prog_sector  (prog_sector),
    .hit_all_prot (hit_all_prot),
    .hit_prog_prot(hit_prog_prot)
  );

  tgl_guard_timer #(
    .ALLPROT_CYC (ALLPROT_CYC),
    .PROGPROT_CYC(PROGPROT_CYC)
  ) u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (op_start),
    .hit_all_prot (hit_all_prot),
    .hit_prog_prot(hit_prog_prot),
    .guard_on     (guard_on)
  );

  tgl_read_qual #(.NSEC(NSEC)) u_qual (
    .op_state (op_state),
    .erase_sel(erase_sel),
    .rd_sector(rd_sector),
    .rd_strobe(rd_strobe),
    .oe_n     (oe_n),
    .guard_on (guard_on),
    .flip_mode(flip_mode),
    .flip_sect(flip_sect)
  );

  assign flip_vec = {flip_sect, flip_mode};

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    tgl_flip u_flip (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(op_start),
      .flip (flip_vec[g]),
      .q    (q_vec[g])
    );
  end

  assign tgl_mode_o   = q_vec[0];
  assign tgl_sect_o   = q_vec[1];
  assign status_sel_o = is_busy(op_state) || guard_on;

endmodule

// File: rtl/tgl_status_chk.sv
module tgl_status_chk #(
  parameter int NSEC = 16,
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_start,
  input logic [2:0]      op_state,
  input logic [NSEC-1:0] erase_sel,
  input logic [NSEC-1:0] prot_mask,
  input logic [SW-1:0]   rd_sector,
  input logic            rd_strobe,
  input logic            oe_n,
  input logic            guard_on,
  input logic            tgl_mode_o,
  input logic            tgl_sect_o,
  input logic            status_sel_o
);

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (!tgl_mode_o && !tgl_sect_o));

  p_oe_high_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && oe_n) |=> ($stable(tgl_mode_o) && $stable(tgl_sect_o)));

  p_susp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && op_state == 3'd3 && !guard_on) |=> $stable(tgl_mode_o));

  p_prog_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && rd_strobe && !oe_n && op_state == 3'd1) |=> (tgl_mode_o != $past(tgl_mode_o)));

  p_unsel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && !erase_sel[rd_sector]) |=> $stable(tgl_sect_o));

  p_all_prot_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_state == 3'd2 && erase_sel != '0 && (erase_sel & ~prot_mask) == '0)
    |=> status_sel_o);

endmodule

bind tgl_status_unit tgl_status_chk #(.NSEC(NSEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_start    (op_start),
  .op_state    (op_state),
  .erase_sel   (erase_sel),
  .prot_mask   (prot_mask),
  .rd_sector   (rd_sector),
  .rd_strobe   (rd_strobe),
  .oe_n        (oe_n),
  .guard_on    (guard_on),
  .tgl_mode_o  (tgl_mode_o),
  .tgl_sect_o  (tgl_sect_o),
  .status_sel_o(status_sel_o)
);

// File: tb/test_tgl_status_unit.sv
module test_tgl_status_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NSEC = 16;
  localparam int SW   = $clog2(NSEC);
  localparam int ALLP = 40;
  localparam int PROGP = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_start = 1'b0;
  logic [2:0]      op_state = 3'd0;
  logic [NSEC-1:0] erase_sel = '0;
  logic [NSEC-1:0] prot_mask = '0;
  logic [SW-1:0]   prog_sector = '0;
  logic [SW-1:0]   rd_sector = '0;
  logic            rd_strobe = 1'b0;
  logic            oe_n = 1'b1;
  logic            tgl_mode_o;
  logic            tgl_sect_o;
  logic            status_sel_o;

  int vectors = 0;
  int miscompares = 0;
  bit m6 = 0;
  bit m2 = 0;
  int mcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgl_status_unit #(.NSEC(NSEC), .ALLPROT_CYC(ALLP), .PROGPROT_CYC(PROGP)) i_tgl_status_unit (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_state(op_state),
    .erase_sel(erase_sel), .prot_mask(prot_mask), .prog_sector(prog_sector),
    .rd_sector(rd_sector), .rd_strobe(rd_strobe), .oe_n(oe_n),
    .tgl_mode_o(tgl_mode_o), .tgl_sect_o(tgl_sect_o), .status_sel_o(status_sel_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit f_busy(input logic [2:0] st);
    return st inside {3'd1, 3'd2, 3'd3, 3'd4};
  endfunction

  function automatic int f_window(input logic [2:0] st, input logic [NSEC-1:0] sel,
                                  input logic [NSEC-1:0] prot, input logic [SW-1:0] ps);
    if (st == 3'd2 && sel != '0 && (sel & ~prot) == '0) return ALLP;
    if ((st == 3'd1 || st == 3'd4) && prot[ps]) return PROGP;
    return 0;
  endfunction

  // One clock: model the edge from present inputs, then check after it.
  task automatic cyc(input string tag);
    bit rd   = rd_strobe && !oe_n;
    bit act6 = (mcnt != 0) || (op_state inside {3'd1, 3'd2, 3'd4});
    bit act2 = (op_state inside {3'd2, 3'd3, 3'd4}) && erase_sel[rd_sector];
    if (op_start) begin
      m6 = 0; m2 = 0;
      mcnt = f_window(op_state, erase_sel, prot_mask, prog_sector);
    end else begin
      if (rd && act6) m6 = ~m6;
      if (rd && act2) m2 = ~m2;
      if (mcnt != 0) mcnt--;
    end
    @(posedge clk); #1;
    chk(tag, "bit6", tgl_mode_o, m6);
    chk(tag, "bit2", tgl_sect_o, m2);
    chk(tag, "sel", status_sel_o, f_busy(op_state) || mcnt != 0);
  endtask

  task automatic rd(input logic [SW-1:0] s, input bit en);
    rd_sector = s; rd_strobe = 1'b1; oe_n = !en;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "bit6", tgl_mode_o, 1'b0);
    chk("R1", "bit2", tgl_sect_o, 1'b0);
    chk("R1", "sel", status_sel_o, 1'b0);
    rst_n = 1'b1;
    cyc("R1");

    // R2: program, reads flip bit6 on every counted read
    op_state = 3'd1; op_start = 1'b1; prot_mask = '0; prog_sector = 4'd2;
    cyc("R6");
    op_start = 1'b0;
    rd(4'd5, 1);
    repeat (5) cyc("R2");

    // R3: output enable high, reads ignored
    oe_n = 1'b1;
    repeat (4) cyc("R3");

    // R5: erase, selected and unselected sectors
    op_state = 3'd2; erase_sel = 16'h00F0; prot_mask = 16'h0010; op_start = 1'b1;
    rd(4'd5, 1);
    cyc("R6");
    op_start = 1'b0;
    repeat (3) cyc("R5");
    rd(4'd1, 1);
    repeat (3) cyc("R5");
    // R4: suspend holds bit6, bit2 still flips on selected sector
    op_state = 3'd3;
    rd(4'd6, 1);
    repeat (3) cyc("R4");
    rd(4'd6, 0);
    cyc("R3");
    op_state = 3'd4;
    rd(4'd6, 1);
    repeat (3) cyc("R2");

    // R7: all-protected erase, controller idle, window times out
    op_state = 3'd2; erase_sel = 16'h0300; prot_mask = 16'h0F00; op_start = 1'b1;
    rd(4'd8, 1);
    cyc("R6");
    op_start = 1'b0; op_state = 3'd0;
    repeat (ALLP - 1) cyc("R7");
    chk("R7", "sel last window cycle", status_sel_o, 1'b1);
    cyc("R7");
    chk("R9", "sel after window", status_sel_o, 1'b0);
    repeat (3) cyc("R4");

    // R8: program to protected sector
    op_state = 3'd1; prog_sector = 4'd9; op_start = 1'b1;
    rd(4'd0, 1);
    cyc("R6");
    op_start = 1'b0; op_state = 3'd0;
    repeat (PROGP) cyc("R8");
    chk("R8", "sel after window", status_sel_o, 1'b0);
    repeat (2) cyc("R9");

    // Random mix
    for (int i = 0; i < 5000; i++) begin
      op_start = ($urandom % 30) == 0;
      if (op_start) begin
        op_state  = 3'(1 + $urandom % 4);
        erase_sel = NSEC'($urandom);
        prot_mask = ($urandom % 2) ? (erase_sel | NSEC'($urandom)) : NSEC'($urandom);
        prog_sector = SW'($urandom);
      end else if (($urandom % 25) == 0) begin
        op_state = 3'($urandom % 5);
      end
      rd_strobe = $urandom % 2;
      oe_n      = ($urandom % 4) == 0;
      rd_sector = SW'($urandom);
      cyc("R9 random R2 R5");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule